// File: doc/BRIEF.md
# UART Receive Line Status Logic

This block holds the 8-bit line status word of a UART. It sits next to the receive path and keeps the receive character FIFO inside itself. Every stored character carries three error tags: parity, framing and break. The block tracks how full the FIFO is and how many of its entries are tagged. From that state, and from the state of the transmit holding and shift registers, it builds the status bits. The host pops characters from the FIFO head and issues a status read strobe. The word is visible on `line_status` at all times. A read strobe clears the bits that clear on read, and that clear takes effect at the next clock edge.

Each error flag belongs to the character that currently sits at the head of the FIFO. The flag is latched when that character reaches the head. When a character arrives while the FIFO is full, the block drops the new character and keeps the stored ones. The summary error bit survives a read for as long as any tagged character is still stored.

Top module: `uart_line_status`

## Requirements
- R1: Bit 0 is 1 exactly when the receive FIFO holds at least one character. `rx_pop` removes the head character, and `rx_head_data` presents the stored characters in arrival order.
- R2: When `rx_valid` is asserted while the FIFO holds DEPTH characters (default 16), bit 1 is set at the next edge. The new character is discarded, does not count as tagged, and leaves the stored contents unchanged.
- R3: Bits 2, 3 and 4 hold the parity, framing and break tags of the head character. The tag vector is ordered {break, framing, parity}, so it maps to bits {4,3,2}. The tags are captured when a character becomes the head, and the bits return to 0 when the FIFO empties.
- R4: A cycle with `stat_rd` high clears bits 1 through 4 at the next edge. The head error bits then stay 0 until another character reaches the head.
- R5: Bit 5 is set at the edge after `thr_load`, when the holding register hands its character to the shifter. It is cleared at the edge after `thr_wr`.
- R6: Bit 6 is 1 only when bit 5 is 1 and `tsr_busy` is 0.
- R7: Bit 7 is set when a character with any nonzero tag enters the FIFO. A status read clears bit 7 only when no tagged character is stored at the time of the read.
- R8: During reset and right after it, the status word reads 0x60.
- R9: When a set event for a bit and a status read (or, for bit 5, a holding write) fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Receive shifter has completed a character |
| rx_data | input | 8 | Completed character |
| rx_tag | input | 3 | Error tags of that character, {break, framing, parity} |
| rx_pop | input | 1 | Remove the head character |
| stat_rd | input | 1 | Status read strobe |
| thr_wr | input | 1 | Write to the transmit holding register |
| thr_load | input | 1 | Holding register moved into the transmit shifter |
| tsr_busy | input | 1 | Transmit shifter holds a character |
| rx_head_data | output | 8 | Character at the FIFO head |
| line_status | output | 8 | Line status word |

## Verification
The assertions assume a few things about the neighbouring logic. `thr_load` is raised only while the holding register has a character in it. `tsr_busy` is low during reset. `rx_pop` is never asserted in the same cycle as a push into a full FIFO. Each stimulus step drives exactly one such pattern. Pops happen only when bit 0 shows a character, and the shifter busy input stays low except in the one step that models a running transmission.

// File: rtl/uls_pkg.sv
package uls_pkg;
  parameter int DATA_W = 8;

  typedef struct packed {
    logic brk;
    logic fe;
    logic pe;
  } err_tag_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    err_tag_t          tag;
  } rx_entry_t;
endpackage

// File: rtl/uls_rx_fifo.sv
module uls_rx_fifo
  import uls_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  err_tag_t          push_tag,
  input  logic              pop,
  output logic              empty,
  output logic              full,
  output logic [DATA_W-1:0] head_data,
  output logic              push_ok,
  output logic              arrive,
  output err_tag_t          arrive_tag,
  output logic              going_empty,
  output logic              tag_none
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  rx_entry_t        mem [DEPTH];
  logic [PW-1:0]    wr_ptr, wr_nxt, rd_ptr, rd_nxt, rd_plus1;
  logic [CW-1:0]    cnt, cnt_nxt, tcnt, tcnt_nxt;
  logic             pop_ok, push_tagged, pop_tagged;

  always_comb begin
    empty       = (cnt == '0);
    full        = (cnt == CW'(DEPTH));
    push_ok     = push & ~full;
    pop_ok      = pop & ~empty;
    push_tagged = push_ok & (|push_tag);
    pop_tagged  = pop_ok & (|mem[rd_ptr].tag);
    rd_plus1    = rd_ptr + PW'(1);
    head_data   = mem[rd_ptr].data;
    // a new character becomes the head: into an empty FIFO, or after a pop
    arrive      = (push_ok & empty) | (pop_ok & ((cnt > CW'(1)) | push_ok));
    arrive_tag  = (cnt <= CW'(1)) ? push_tag : mem[rd_plus1].tag;
    going_empty = pop_ok & ~push_ok & (cnt == CW'(1));
    tag_none    = (tcnt == '0);
    wr_nxt      = push_ok ? wr_ptr + PW'(1) : wr_ptr;
    rd_nxt      = pop_ok ? rd_plus1 : rd_ptr;
    cnt_nxt     = cnt;
    if (push_ok && !pop_ok) cnt_nxt = cnt + CW'(1);
    if (pop_ok && !push_ok) cnt_nxt = cnt - CW'(1);
    tcnt_nxt    = tcnt;
    if (push_tagged && !pop_tagged) tcnt_nxt = tcnt + CW'(1);
    if (pop_tagged && !push_tagged) tcnt_nxt = tcnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      tcnt   <= '0;
    end else begin
      wr_ptr <= wr_nxt;
      rd_ptr <= rd_nxt;
      cnt    <= cnt_nxt;
      tcnt   <= tcnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= '{data: push_data, tag: push_tag};
  end

  // R2
  drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(cnt));
  // R7
  tag_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt <= cnt);
  // R1
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> empty);
endmodule

// File: rtl/uls_err_flags.sv
module uls_err_flags
  import uls_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     stat_rd,
  input  logic     ovr_evt,
  input  logic     arrive,
  input  err_tag_t arrive_tag,
  input  logic     going_empty,
  input  logic     tag_push,
  input  logic     tag_none,
  output logic     ovr,
  output err_tag_t head_err,
  output logic     rxfe
);
  logic     ovr_nxt, rxfe_nxt;
  err_tag_t head_nxt;

  always_comb begin
    ovr_nxt  = ovr_evt | (ovr & ~stat_rd);
    head_nxt = head_err;
    if (stat_rd || going_empty) head_nxt = '0;
    if (arrive)                 head_nxt = arrive_tag;
    rxfe_nxt = tag_push | (rxfe & ~(stat_rd & tag_none));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr      <= 1'b0;
      head_err <= '0;
      rxfe     <= 1'b0;
    end else begin
      ovr      <= ovr_nxt;
      head_err <= head_nxt;
      rxfe     <= rxfe_nxt;
    end
  end

  // R2
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ovr);
  // R4
  overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ovr_evt) |=> !ovr);
  // R4
  head_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !arrive) |=> (head_err == '0));
  // R9
  summary_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_push |=> rxfe);
endmodule

// File: rtl/uls_tx_flags.sv
module uls_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_wr,
  input  logic thr_load,
  input  logic tsr_busy,
  output logic thre,
  output logic temt
);
  logic thre_nxt;

  always_comb begin
    thre_nxt = thr_load | (thre & ~thr_wr);
    temt     = thre & ~tsr_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thre <= 1'b1;
    else        thre <= thre_nxt;
  end

  // R5
  hold_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !thr_load) |=> !thre);
  // R9
  hold_load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_load |=> thre);
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import uls_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [2:0]        rx_tag,
  input  logic              rx_pop,
  input  logic              stat_rd,
  input  logic              thr_wr,
  input  logic              thr_load,
  input  logic              tsr_busy,
  output logic [DATA_W-1:0] rx_head_data,
  output logic [7:0]        line_status
);
  logic     sync_q1, rst_sync_n;
  logic     empty, full, push_ok, arrive, going_empty, tag_none;
  logic     ovr, rxfe, thre, temt;
  err_tag_t arrive_tag, head_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q1    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      sync_q1    <= 1'b1;
      rst_sync_n <= sync_q1;
    end
  end

  uls_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_sync_n),
    .push(rx_valid), .push_data(rx_data), .push_tag(err_tag_t'(rx_tag)),
    .pop(rx_pop), .empty(empty), .full(full), .head_data(rx_head_data),
    .push_ok(push_ok), .arrive(arrive), .arrive_tag(arrive_tag),
    .going_empty(going_empty), .tag_none(tag_none)
  );

  uls_err_flags u_err (
    .clk(clk), .rst_n(rst_sync_n), .stat_rd(stat_rd),
    .ovr_evt(rx_valid & full), .arrive(arrive), .arrive_tag(arrive_tag),
    .going_empty(going_empty), .tag_push(push_ok & (|rx_tag)),
    .tag_none(tag_none), .ovr(ovr), .head_err(head_err), .rxfe(rxfe)
  );

  uls_tx_flags u_tx (
    .clk(clk), .rst_n(rst_sync_n), .thr_wr(thr_wr), .thr_load(thr_load),
    .tsr_busy(tsr_busy), .thre(thre), .temt(temt)
  );

  assign line_status = {rxfe, temt, thre, head_err.brk, head_err.fe,
                        head_err.pe, ovr, ~empty};

  // R6
  temt_implies_thre_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    line_status[6] |-> line_status[5]);
  // R7
  summary_held_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tag_none |-> line_status[7]);
endmodule

// File: tb/tb_uart_line_status.sv
module tb_uart_line_status;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_valid, rx_pop, stat_rd, thr_wr, thr_load, tsr_busy;
  logic [7:0] rx_data;
  logic [2:0] rx_tag;
  logic [7:0] rx_head_data, line_status;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  uart_line_status dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_tag(rx_tag), .rx_pop(rx_pop), .stat_rd(stat_rd), .thr_wr(thr_wr),
    .thr_load(thr_load), .tsr_busy(tsr_busy), .rx_head_data(rx_head_data),
    .line_status(line_status)
  );

  // {push, tag{brk,fe,pe}, pop, rd, wr, load, busy, expected status after edge}
  localparam int NV = 15;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 3'b000, 5'b00000, 8'h61},  // R1 push clean
    {1'b0, 3'b000, 5'b00100, 8'h01},  // R5 holding write
    {1'b0, 3'b000, 5'b00011, 8'h21},  // R5 R6 load, shifter busy
    {1'b0, 3'b000, 5'b00000, 8'h61},  // R6 shifter idle
    {1'b1, 3'b001, 5'b00000, 8'hE1},  // R7 tagged push behind clean head
    {1'b0, 3'b000, 5'b10000, 8'hE5},  // R3 parity char reaches head
    {1'b0, 3'b000, 5'b01000, 8'hE1},  // R4 R7 read clears parity, summary held
    {1'b0, 3'b000, 5'b10000, 8'hE0},  // R1 FIFO empties
    {1'b0, 3'b000, 5'b01000, 8'h60},  // R7 read with no tagged char left
    {1'b1, 3'b010, 5'b00000, 8'hE9},  // R3 framing char into empty FIFO
    {1'b1, 3'b100, 5'b01000, 8'hE1},  // R4 R9 read with tagged push
    {1'b0, 3'b000, 5'b10000, 8'hF1},  // R3 break char at head
    {1'b0, 3'b000, 5'b11000, 8'hE0},  // R3 R7 pop to empty with read
    {1'b0, 3'b000, 5'b01000, 8'h60},  // R7 final read clears summary
    {1'b0, 3'b000, 5'b00110, 8'h60}   // R9 load wins over write
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    rx_valid = 0; rx_pop = 0; stat_rd = 0; thr_wr = 0; thr_load = 0;
    rx_tag = 3'b000; rx_data = 8'h00;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    tsr_busy = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R8 during reset", line_status, 8'h60);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    check("R8 after reset", line_status, 8'h60);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rx_valid = VEC[i][16];
      rx_tag   = VEC[i][15:13];
      rx_data  = 8'(i);
      rx_pop   = VEC[i][12];
      stat_rd  = VEC[i][11];
      thr_wr   = VEC[i][10];
      thr_load = VEC[i][9];
      tsr_busy = VEC[i][8];
      step();
      check($sformatf("R1/R3/R4/R5/R6/R7/R9 table step %0d", i), line_status, VEC[i][7:0]);
    end
    @(negedge clk); idle(); tsr_busy = 0;

    // fill the FIFO
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = 8'h40 + 8'(i);
      step();
    end
    @(negedge clk); idle();
    step();
    check("R1 full FIFO no overrun yet", line_status, 8'h61);
    // R2: tagged push into a full FIFO is dropped, no summary bit
    @(negedge clk); rx_valid = 1; rx_data = 8'hFF; rx_tag = 3'b100;
    step();
    check("R2 overrun set, tagged drop ignored", line_status, 8'h63);
    // R9: read and another overrun together
    @(negedge clk); rx_valid = 1; rx_data = 8'hEE; stat_rd = 1; rx_tag = 3'b000;
    step();
    check("R9 overrun wins over read", line_status, 8'h63);
    @(negedge clk); idle(); stat_rd = 1;
    step();
    check("R4 read clears overrun", line_status, 8'h61);
    @(negedge clk); idle();
    // R2: contents unchanged, R1 order preserved
    for (int i = 0; i < 16; i++) begin
      step();
      check($sformatf("R2 head data %0d", i), rx_head_data, 8'h40 + 8'(i));
      @(negedge clk); rx_pop = 1;
      @(negedge clk); rx_pop = 0;
    end
    step();
    check("R1 drained FIFO", line_status, 8'h60);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule